// File: doc/BRIEF.md
# Program Counter and Exception Sequencer

This block owns the control-flow state of a small 32-bit RISC core. It holds the program counter, the following-fetch register, the status word, and the saved PC and saved status used on trap entry and return. A parameter selects between a pipeline with one branch delay slot and one without. Every instruction spends three clocks in the block: decode, execute, then write-back together with the next fetch. The requests presented during the execute clock decide the next fetch address, the link value and any change to the status and saved registers. These requests are relative branch, register jump, return from exception, explicit exception with a cause, external interrupt, and a special-register read or write.

The surrounding core decodes the instruction, reads the register file and holds the request lines steady for the whole instruction. It takes `fetch_pc` as the address of the next fetch and writes `link_addr` into the link register (register 9) on call instructions. The status, saved-PC and saved-status registers are reached through a small indexed special-register port. An index the block does not implement raises an illegal-instruction exception.

Top module: `pcseq_top`

## Requirements
- R1: The phase output cycles decode (0), execute (1), write-back/fetch (2) in that fixed order, and reset leaves it in write-back/fetch (2).
- R2: PC, next-PC, status and both saved registers change only on the clock edge that ends the execute phase.
- R3: With no redirect and no exception, delay-slot mode moves next-PC into PC and advances next-PC by 4, while the non-delay-slot mode advances PC by 4.
- R4: A relative branch target is PC plus the 26-bit two's-complement offset times 4. In delay-slot mode it replaces next-PC (one more sequential instruction runs first). Otherwise it replaces PC directly.
- R5: A register jump (to `jmp_target`) and a return from exception (to the saved PC) redirect the same way as a branch. When several are requested, branch wins over return, and return wins over register jump.
- R6: During execute, `link_addr` equals next-PC + 4 in delay-slot mode and PC + 4 otherwise.
- R7: Exception entry stores the PC that would otherwise have followed into the saved PC. It stores the status (including a same-instruction status write) into the saved status, clears the whole status word, and sets PC to base + vector, with next-PC at base + vector + 4. Base is the start address minus the reset vector offset. Cause code 1 selects the system-call vector, 2 selects the trap vector, and 0 or 3 select the illegal-instruction vector.
- R8: An interrupt is taken, at the interrupt vector, only when status bit IE_BIT (bit 2) is set, no explicit or illegal-access exception is raised, and no branch, jump or return is requested. A branch, jump or return also suppresses explicit exceptions.
- R9: A return from exception loads the status word from the saved status.
- R10: Special-register index 0 is the status, 1 the saved PC and 2 the saved status. A read returns the value combinationally, and a write takes effect at the end of execute. Any other index, on a read or a write, returns 0, writes nothing and raises an illegal-instruction exception.
- R11: Synchronous reset sets PC to the start address and next-PC to the start address + 4, and clears the status and both saved registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_req | input | 1 | Take relative branch this instruction |
| jmp_req | input | 1 | Jump to register target |
| rfe_req | input | 1 | Return from exception |
| exc_req | input | 1 | Raise explicit exception |
| exc_cause | input | 2 | Cause of explicit exception |
| irq | input | 1 | External interrupt request (level) |
| br_off | input | 26 | Signed word offset for branch |
| jmp_target | input | 32 | Register jump target |
| spr_rd | input | 1 | Special-register read |
| spr_wr | input | 1 | Special-register write |
| spr_idx | input | 4 | Special-register index |
| spr_wdata | input | 32 | Special-register write data |
| phase | output | 2 | Current instruction phase |
| fetch_pc | output | 32 | Program counter / next fetch address |
| link_addr | output | 32 | Return address for link writes |
| status | output | 32 | Status register |
| spr_rdata | output | 32 | Special-register read data |

## Verification
The bench builds two copies side by side, one with the delay slot enabled and one without, both with start address 0x2100 and reset offset 0x100, so the vector base is 0x2000. Both copies get the same request stream, which makes the one-instruction lag of delay-slot redirects against immediate redirects visible on every branch, jump and return. The stream sweeps branch offsets up to both extremes of the 26-bit range, all 16 special-register indices, all four cause codes, and every combination of interrupt enable with interrupt request and redirect.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        PH_DEC = 2'd0,
        PH_EXE = 2'd1,
        PH_WB  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        CS_ILLEGAL = 2'd0,
        CS_SYSCALL = 2'd1,
        CS_TRAP    = 2'd2,
        CS_SPARE   = 2'd3
    } cause_e;

    localparam int SPR_IDX_W = 4;
    localparam logic [SPR_IDX_W-1:0] SPR_STATUS   = 4'd0;
    localparam logic [SPR_IDX_W-1:0] SPR_SAVED_PC = 4'd1;
    localparam logic [SPR_IDX_W-1:0] SPR_SAVED_ST = 4'd2;

    // Control-flow requests of one instruction
    typedef struct packed {
        logic   br;
        logic   jmp;
        logic   rfe;
        logic   exc;
        cause_e cause;
        logic   irq;
    } flow_req_t;

    function automatic logic spr_known(input logic [SPR_IDX_W-1:0] idx);
        return (idx == SPR_STATUS) || (idx == SPR_SAVED_PC) || (idx == SPR_SAVED_ST);
    endfunction

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_WB:   return PH_DEC;
            PH_DEC:  return PH_EXE;
            default: return PH_WB;
        endcase
    endfunction

endpackage

// File: rtl/pcseq_phase.sv
module pcseq_phase
    import pcseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   exe
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_WB;
        else     phase_q <= phase_after(phase_q);
    end

    assign phase = phase_q;
    assign exe   = (phase_q == PH_EXE);

    AST_WB_TO_DEC: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WB) |=> (phase_q == PH_DEC)); // R1
    AST_DEC_TO_EXE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DEC) |=> (phase_q == PH_EXE)); // R1
    AST_EXE_TO_WB: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXE) |=> (phase_q == PH_WB)); // R1

endmodule

// File: rtl/pcseq_spr.sv
module pcseq_spr
    import pcseq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IE_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 exe,
    input  logic                 spr_rd,
    input  logic                 spr_wr,
    input  logic [SPR_IDX_W-1:0] spr_idx,
    input  logic [XLEN-1:0]      spr_wdata,
    input  logic                 take_exc,
    input  logic                 rfe,
    input  logic [XLEN-1:0]      exc_pc,
    output logic [XLEN-1:0]      spr_rdata,
    output logic                 spr_ill,
    output logic [XLEN-1:0]      sr,
    output logic [XLEN-1:0]      saved_pc,
    output logic                 ie
);

    logic [XLEN-1:0] sr_q, epc_q, esr_q, sr_mid;
    logic            known, wr_sr, wr_epc, wr_esr;

    assign known   = spr_known(spr_idx);
    assign spr_ill = (spr_rd | spr_wr) & ~known;
    assign wr_sr   = spr_wr & (spr_idx == SPR_STATUS);
    assign wr_epc  = spr_wr & (spr_idx == SPR_SAVED_PC);
    assign wr_esr  = spr_wr & (spr_idx == SPR_SAVED_ST);
    assign sr_mid  = wr_sr ? spr_wdata : sr_q;

    always_comb begin
        case (spr_idx)
            SPR_STATUS:   spr_rdata = sr_q;
            SPR_SAVED_PC: spr_rdata = epc_q;
            SPR_SAVED_ST: spr_rdata = esr_q;
            default:      spr_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            epc_q <= '0;
            esr_q <= '0;
        end else if (exe) begin
            if (take_exc) begin
                epc_q <= exc_pc;
                esr_q <= sr_mid;
                sr_q  <= '0;
            end else begin
                sr_q <= rfe ? esr_q : sr_mid;
                if (wr_epc) epc_q <= spr_wdata;
                if (wr_esr) esr_q <= spr_wdata;
            end
        end
    end

    assign sr       = sr_q;
    assign saved_pc = epc_q;
    assign ie       = sr_q[IE_BIT];

    AST_EXC_CLEARS_ST: assert property (@(posedge clk) disable iff (rst)
        (exe && take_exc) |=> (sr_q == '0)); // R7
    AST_EXC_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
        (exe && take_exc) |=> (epc_q == $past(exc_pc))); // R7
    AST_RFE_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (exe && rfe && !take_exc) |=> (sr_q == $past(esr_q))); // R9
    AST_ST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exe) |=> ($stable(sr_q) && $stable(epc_q) && $stable(esr_q))); // R2
    AST_ILL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        spr_ill |-> (spr_rdata == '0)); // R10

endmodule

// File: rtl/pcseq_nextpc.sv
module pcseq_nextpc
    import pcseq_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              OFS_W       = 26,
    parameter bit              DELAY_SLOT  = 1'b1,
    parameter logic [XLEN-1:0] VEC_BASE    = '0,
    parameter logic [XLEN-1:0] VEC_ILLEGAL = 'h700,
    parameter logic [XLEN-1:0] VEC_SYSCALL = 'hC00,
    parameter logic [XLEN-1:0] VEC_TRAP    = 'hE00,
    parameter logic [XLEN-1:0] VEC_IRQ     = 'h500
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  npc,
    input  flow_req_t        req,
    input  logic [OFS_W-1:0] br_off,
    input  logic [XLEN-1:0]  jmp_tgt,
    input  logic [XLEN-1:0]  saved_pc,
    input  logic             ie,
    input  logic             spr_ill,
    output logic [XLEN-1:0]  pc_nxt,
    output logic [XLEN-1:0]  npc_nxt,
    output logic [XLEN-1:0]  link,
    output logic [XLEN-1:0]  exc_pc,
    output logic             take_exc
);

    localparam int PAD_W = XLEN - OFS_W - 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] br_tgt, redir_tgt, flow_pc, flow_npc, vec;
    logic            redirect;

    assign br_tgt    = pc + {{PAD_W{br_off[OFS_W-1]}}, br_off, 2'b00};
    assign redirect  = req.br | req.rfe | req.jmp;
    assign redir_tgt = req.br ? br_tgt : (req.rfe ? saved_pc : jmp_tgt);

    generate
        if (DELAY_SLOT) begin : g_slot
            assign flow_pc  = npc;
            assign flow_npc = redirect ? redir_tgt : npc + STEP;
            assign link     = npc + STEP;
        end else begin : g_noslot
            assign flow_pc  = redirect ? redir_tgt : pc + STEP;
            assign flow_npc = flow_pc + STEP;
            assign link     = pc + STEP;
        end
    endgenerate

    always_comb begin
        if (req.exc) begin
            case (req.cause)
                CS_SYSCALL: vec = VEC_SYSCALL;
                CS_TRAP:    vec = VEC_TRAP;
                default:    vec = VEC_ILLEGAL;
            endcase
        end else if (spr_ill) begin
            vec = VEC_ILLEGAL;
        end else begin
            vec = VEC_IRQ;
        end
    end

    assign take_exc = ~redirect & (req.exc | spr_ill | (req.irq & ie));
    assign exc_pc   = flow_pc;
    assign pc_nxt   = take_exc ? VEC_BASE + vec : flow_pc;
    assign npc_nxt  = take_exc ? VEC_BASE + vec + STEP : flow_npc;

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter bit          DELAY_SLOT  = 1'b1,
    parameter int          XLEN        = 32,
    parameter int          OFS_W       = 26,
    parameter int          IE_BIT      = 2,
    parameter logic [31:0] START_ADDR  = 32'h0000_2100,
    parameter logic [31:0] VEC_RESET   = 32'h0000_0100,
    parameter logic [31:0] VEC_ILLEGAL = 32'h0000_0700,
    parameter logic [31:0] VEC_SYSCALL = 32'h0000_0C00,
    parameter logic [31:0] VEC_TRAP    = 32'h0000_0E00,
    parameter logic [31:0] VEC_IRQ     = 32'h0000_0500
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 br_req,
    input  logic                 jmp_req,
    input  logic                 rfe_req,
    input  logic                 exc_req,
    input  logic [1:0]           exc_cause,
    input  logic                 irq,
    input  logic [OFS_W-1:0]     br_off,
    input  logic [XLEN-1:0]      jmp_target,
    input  logic                 spr_rd,
    input  logic                 spr_wr,
    input  logic [SPR_IDX_W-1:0] spr_idx,
    input  logic [XLEN-1:0]      spr_wdata,
    output logic [1:0]           phase,
    output logic [XLEN-1:0]      fetch_pc,
    output logic [XLEN-1:0]      link_addr,
    output logic [XLEN-1:0]      status,
    output logic [XLEN-1:0]      spr_rdata
);

    localparam logic [XLEN-1:0] START    = XLEN'(START_ADDR);
    localparam logic [XLEN-1:0] VEC_BASE = XLEN'(START_ADDR - VEC_RESET);

    phase_e          phase_q;
    logic            exe, ie, spr_ill, take_exc;
    logic [XLEN-1:0] pc_q, npc_q, pc_nxt, npc_nxt, exc_pc, saved_pc;
    flow_req_t       req;

    assign req = '{br: br_req, jmp: jmp_req, rfe: rfe_req, exc: exc_req,
                   cause: cause_e'(exc_cause), irq: irq};

    pcseq_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase_q),
        .exe   (exe)
    );

    pcseq_spr #(.XLEN(XLEN), .IE_BIT(IE_BIT)) u_spr (
        .clk       (clk),
        .rst       (rst),
        .exe       (exe),
        .spr_rd    (spr_rd),
        .spr_wr    (spr_wr),
        .spr_idx   (spr_idx),
        .spr_wdata (spr_wdata),
        .take_exc  (take_exc),
        .rfe       (rfe_req),
        .exc_pc    (exc_pc),
        .spr_rdata (spr_rdata),
        .spr_ill   (spr_ill),
        .sr        (status),
        .saved_pc  (saved_pc),
        .ie        (ie)
    );

    pcseq_nextpc #(
        .XLEN        (XLEN),
        .OFS_W       (OFS_W),
        .DELAY_SLOT  (DELAY_SLOT),
        .VEC_BASE    (VEC_BASE),
        .VEC_ILLEGAL (XLEN'(VEC_ILLEGAL)),
        .VEC_SYSCALL (XLEN'(VEC_SYSCALL)),
        .VEC_TRAP    (XLEN'(VEC_TRAP)),
        .VEC_IRQ     (XLEN'(VEC_IRQ))
    ) u_nextpc (
        .pc       (pc_q),
        .npc      (npc_q),
        .req      (req),
        .br_off   (br_off),
        .jmp_tgt  (jmp_target),
        .saved_pc (saved_pc),
        .ie       (ie),
        .spr_ill  (spr_ill),
        .pc_nxt   (pc_nxt),
        .npc_nxt  (npc_nxt),
        .link     (link_addr),
        .exc_pc   (exc_pc),
        .take_exc (take_exc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= START;
            npc_q <= START + XLEN'(4);
        end else if (exe) begin
            pc_q  <= pc_nxt;
            npc_q <= npc_nxt;
        end
    end

    assign phase    = phase_q;
    assign fetch_pc = pc_q;

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (pc_q == START)); // R11
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exe) |=> ($stable(pc_q) && $stable(npc_q))); // R2
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (exe && !ie && !exc_req && !spr_ill) |-> !take_exc); // R8
    AST_BRANCH_NO_EXC: assert property (@(posedge clk) disable iff (rst)
        (exe && br_req) |-> !take_exc); // R8
    AST_EXC_VECTORED: assert property (@(posedge clk) disable iff (rst)
        (exe && take_exc) |=> (npc_q == pc_q + XLEN'(4))); // R7

endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_req = 0, jmp_req = 0, rfe_req = 0, exc_req = 0, irq = 0;
    logic [1:0]  exc_cause = 0;
    logic [25:0] br_off = 0;
    logic [31:0] jmp_target = 0, spr_wdata = 0;
    logic        spr_rd = 0, spr_wr = 0;
    logic [3:0]  spr_idx = 0;

    logic [1:0]  phase [2];
    logic [31:0] fpc [2], link [2], st [2], rdata [2];

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state, index 0: no delay slot, 1: delay slot
    logic [31:0] m_pc [2], m_npc [2], m_sr [2], m_epc [2], m_esr [2];

    localparam logic [31:0] BASE = 32'h2000;

    always #10 clk = ~clk;

    pcseq_top #(.DELAY_SLOT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .br_req(br_req), .jmp_req(jmp_req), .rfe_req(rfe_req),
        .exc_req(exc_req), .exc_cause(exc_cause), .irq(irq), .br_off(br_off),
        .jmp_target(jmp_target), .spr_rd(spr_rd), .spr_wr(spr_wr), .spr_idx(spr_idx),
        .spr_wdata(spr_wdata), .phase(phase[0]), .fetch_pc(fpc[0]), .link_addr(link[0]),
        .status(st[0]), .spr_rdata(rdata[0])
    );

    pcseq_top #(.DELAY_SLOT(1'b1)) u_dut_ds (
        .clk(clk), .rst(rst), .br_req(br_req), .jmp_req(jmp_req), .rfe_req(rfe_req),
        .exc_req(exc_req), .exc_cause(exc_cause), .irq(irq), .br_off(br_off),
        .jmp_target(jmp_target), .spr_rd(spr_rd), .spr_wr(spr_wr), .spr_idx(spr_idx),
        .spr_wdata(spr_wdata), .phase(phase[1]), .fetch_pc(fpc[1]), .link_addr(link[1]),
        .status(st[1]), .spr_rdata(rdata[1])
    );

    task automatic check(input string tag, input int m, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s slot=%0d actual=%h expected=%h", tag, m, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic br, input logic jmp, input logic rfe,
                        input logic exc, input logic [1:0] cause, input logic irq_i,
                        input logic [25:0] off, input logic [31:0] tgt,
                        input logic rd, input logic wr, input logic [3:0] idx, input logic [31:0] wd);
        logic [31:0] e_link [2], e_rd [2], e_pc [2], e_npc [2], e_sr [2], e_epc [2], e_esr [2];
        logic [31:0] sx, rtgt, fp, fn, srm, vec, pc0 [2];
        logic        ill, redir, take;
        br_req = br; jmp_req = jmp; rfe_req = rfe; exc_req = exc; exc_cause = cause;
        irq = irq_i; br_off = off; jmp_target = tgt; spr_rd = rd; spr_wr = wr;
        spr_idx = idx; spr_wdata = wd;
        sx    = {{4{off[25]}}, off, 2'b00};
        ill   = (rd || wr) && (idx > 4'd2);
        redir = br || jmp || rfe;
        for (int m = 0; m < 2; m++) begin
            pc0[m]  = m_pc[m];
            e_rd[m] = (idx == 0) ? m_sr[m] : (idx == 1) ? m_epc[m] : (idx == 2) ? m_esr[m] : 32'h0;
            rtgt    = br ? m_pc[m] + sx : (rfe ? m_epc[m] : tgt);
            if (m == 1) begin
                fp = m_npc[m]; fn = redir ? rtgt : m_npc[m] + 4; e_link[m] = m_npc[m] + 4;
            end else begin
                fp = redir ? rtgt : m_pc[m] + 4; fn = fp + 4; e_link[m] = m_pc[m] + 4;
            end
            srm  = (wr && idx == 0) ? wd : m_sr[m];
            take = !redir && (exc || ill || (irq_i && m_sr[m][2]));
            vec  = exc ? ((cause == 2'd1) ? 32'hC00 : (cause == 2'd2) ? 32'hE00 : 32'h700)
                       : (ill ? 32'h700 : 32'h500);
            e_epc[m] = m_epc[m]; e_esr[m] = m_esr[m];
            if (take) begin
                e_epc[m] = fp; e_esr[m] = srm; e_sr[m] = 0;
                e_pc[m] = BASE + vec; e_npc[m] = BASE + vec + 4;
            end else begin
                e_sr[m] = rfe ? m_esr[m] : srm;
                if (wr && idx == 1) e_epc[m] = wd;
                if (wr && idx == 2) e_esr[m] = wd;
                e_pc[m] = fp; e_npc[m] = fn;
            end
        end
        @(posedge clk); @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check("R1 decode phase", m, {30'd0, phase[m]}, 32'd0);
            check("R2 pc held in decode", m, fpc[m], pc0[m]);
        end
        @(posedge clk); @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check("R1 execute phase", m, {30'd0, phase[m]}, 32'd1);
            check("R6 link", m, link[m], e_link[m]);
            if (rd) check("R10 spr read", m, rdata[m], e_rd[m]);
        end
        @(posedge clk); @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check("R1 writeback phase", m, {30'd0, phase[m]}, 32'd2);
            check({tag, " pc"}, m, fpc[m], e_pc[m]);
            check({tag, " status"}, m, st[m], e_sr[m]);
            m_pc[m] = e_pc[m]; m_npc[m] = e_npc[m]; m_sr[m] = e_sr[m];
            m_epc[m] = e_epc[m]; m_esr[m] = e_esr[m];
        end
        br_req = 0; jmp_req = 0; rfe_req = 0; exc_req = 0; irq = 0;
        spr_rd = 0; spr_wr = 0;
    endtask

    task automatic nop(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic spr_write(input string tag, input logic [3:0] idx, input logic [31:0] v);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, idx, v);
    endtask

    task automatic spr_read(input string tag, input logic [3:0] idx);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, idx, 0);
    endtask

    initial begin
        logic [25:0] offs [8];
        offs[0] = 26'd0; offs[1] = 26'd1; offs[2] = 26'h3FF_FFFF; offs[3] = 26'h1FF_FFFF;
        offs[4] = 26'h200_0000; offs[5] = 26'd5; offs[6] = 26'h3FF_FFF9; offs[7] = 26'd64;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 2; m++) begin
            m_pc[m] = 32'h2100; m_npc[m] = 32'h2104; m_sr[m] = 0; m_epc[m] = 0; m_esr[m] = 0;
            check("R11 reset pc", m, fpc[m], 32'h2100);
            check("R11 reset status", m, st[m], 32'h0);
            check("R1 reset phase", m, {30'd0, phase[m]}, 32'd2);
        end
        spr_read("R11 reset saved pc", 4'd1);
        spr_read("R11 reset saved status", 4'd2);

        // R3 sequential flow
        for (int i = 0; i < 3; i++) nop("R3 sequential");

        // R4 branch offset sweep, each followed by a plain instruction
        for (int i = 0; i < 8; i++) begin
            step("R4 branch", 1, 0, 0, 0, 0, 0, offs[i], 0, 0, 0, 0, 0);
            nop("R4 after branch");
        end

        // R5 register jump, priority cases
        step("R5 jump", 0, 1, 0, 0, 0, 0, 0, 32'h0000_4000, 0, 0, 0, 0);
        nop("R5 after jump");
        step("R5 branch over jump", 1, 1, 0, 0, 0, 0, 26'd8, 32'h0000_5000, 0, 0, 0, 0);
        nop("R5 after branch");

        // R10 special-register writes and reads
        spr_write("R10 write saved pc", 4'd1, 32'h0000_3000);
        spr_write("R10 write saved status", 4'd2, 32'h0000_00A5);
        spr_write("R10 write status", 4'd0, 32'h0000_0011);
        spr_read("R10 read saved pc", 4'd1);
        spr_read("R10 read saved status", 4'd2);
        spr_read("R10 read status", 4'd0);

        // R9 return from exception, and rfe over jump priority (R5)
        step("R9 return", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        nop("R9 after return");
        spr_write("R5 set saved pc", 4'd1, 32'h0000_3800);
        step("R5 return over jump", 0, 1, 1, 0, 0, 0, 0, 32'h0000_6000, 0, 0, 0, 0);
        nop("R5 after return");

        // R8 interrupt gating sweep: IE x irq x redirect
        for (int ie = 0; ie < 2; ie++) begin
            for (int rq = 0; rq < 2; rq++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    spr_write("R8 set status", 4'd0, ie ? 32'h0000_0004 : 32'h0000_0000);
                    step("R8 interrupt", rd[0], 0, 0, 0, 0, rq[0], 26'd3, 0, 0, 0, 0, 0);
                    nop("R8 after");
                end
            end
        end

        // R7 explicit exception causes, with IE set beforehand
        for (int c = 0; c < 4; c++) begin
            spr_write("R7 set status", 4'd0, 32'h0000_0006);
            step("R7 exception", 0, 0, 0, 1, c[1:0], 1, 0, 0, 0, 0, 0, 0);
            spr_read("R7 saved pc", 4'd1);
            spr_read("R7 saved status", 4'd2);
        end
        // R7 same-instruction status write lands in saved status
        step("R7 write then trap", 0, 0, 0, 1, 2'd2, 0, 0, 0, 0, 1, 4'd0, 32'h0000_0F0F);
        spr_read("R7 saved status after write", 4'd2);
        // R8 branch suppresses explicit exception
        step("R8 branch beats exception", 1, 0, 0, 1, 2'd1, 0, 26'd2, 0, 0, 0, 0, 0);
        nop("R8 after");

        // R10 full index sweep: unknown indices raise illegal exception
        spr_write("R10 seed saved status", 4'd2, 32'h0000_0055);
        for (int i = 0; i < 16; i++) spr_read("R10 index sweep", i[3:0]);
        spr_write("R10 unknown write", 4'd9, 32'hDEAD_BEEF);
        spr_read("R10 status after unknown write", 4'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule